// File: doc/BRIEF.md
# Dependence-Based Instruction Steering Unit

This unit sits after rename. Each cycle it takes at most one instruction and places it in one of a set of small in-order instruction buffers. The buffers belong to execution units (EUs), and the EUs are grouped into clusters. The aim is to lay each dependence chain down the length of a single buffer, so that independent chains sit in different buffers and issue in parallel. It keeps a table indexed by architectural register. Each entry names the buffer of the register's latest producer, holds that producer's tag, and records whether a consumer has already been queued behind it. It also keeps one empty flag per buffer, driven by occupancy signals that come back from the buffers.

A consumer is appended directly behind its producer only while that producer has no other consumer. Otherwise the consumer takes an empty buffer, and the producer's cluster is searched first. An instruction with no outstanding source starts a new chain in the lowest-numbered empty buffer. When no allowed buffer exists, the instruction is stalled and nothing changes. When a consumer lands on a different EU from a producer, the unit tells that producer's buffer which EU will need the result. A completion port retires table entries, so that later readers of a finished register see it as not outstanding.

Top module: `dep_steer`

## Requirements
- R1: After reset, with no instruction offered, steer_accept, steer_stall and ntf_valid are all 0. Every buffer is empty and no register has a producer, so the first instruction without sources goes to buffer 0.
- R2: Buffer IDs are numbered eu*BUFS_PER_EU+slot, and the cluster of an EU is eu/EU_PER_CLU. An instruction with no outstanding source goes to the lowest-numbered empty buffer of the whole unit.
- R3: A source is outstanding when its valid flag is set and its register's table entry holds a live producer. If exactly one source is outstanding and its producer has no consumer yet, the instruction goes to that producer's buffer.
- R4: If exactly one source is outstanding and its producer already has a consumer, the instruction goes to the lowest-numbered empty buffer in that producer's cluster. If that cluster has no empty buffer, the instruction stalls, even when another cluster has empty buffers.
- R5: If two different registers are outstanding, the instruction goes behind the source-0 producer if it is free of a consumer, and otherwise behind the source-1 producer if that one is free. If neither is free, it goes to the lowest-numbered empty buffer in source 0's cluster, then in source 1's cluster. Two sources naming the same register count as one.
- R6: When no allowed buffer exists, steer_stall is 1 and steer_accept is 0 in that cycle. The table and the empty flags are left as they were.
- R7: For each outstanding source k whose producer buffer lies on a different EU from the chosen buffer, ntf_valid[k] is 1 during the accept cycle. In that cycle ntf_buf<k> carries the producer's buffer and ntf_eu carries the chosen buffer's EU.
- R8: An accepted instruction that has a destination makes that register's entry name the chosen buffer and tag, with no consumer. Every outstanding source's producer is marked as having a consumer.
- R9: A completion clears a table entry only when both the entry's buffer and its tag equal cmp_buf and cmp_tag. It takes effect from the next cycle. A completion whose tag does not match is ignored.
- R10: A buffer's empty flag drops on the clock edge at which an instruction is steered into it. The flag rises again on the edge that ends any cycle in which buf_occupied for that buffer is 0 and nothing is steered into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_dst_vld | input | 1 | Instruction writes a destination register |
| in_dst | input | REG_W (4) | Destination register |
| in_src0_vld | input | 1 | Source 0 is pending at rename |
| in_src0 | input | REG_W (4) | Source 0 register |
| in_src1_vld | input | 1 | Source 1 is pending at rename |
| in_src1 | input | REG_W (4) | Source 1 register |
| in_tag | input | TAG_W (4) | Tag of the offered instruction |
| cmp_valid | input | 1 | A producer has completed |
| cmp_buf | input | BUF_W (4) | Buffer of the completed producer |
| cmp_tag | input | TAG_W (4) | Tag of the completed producer |
| buf_occupied | input | NUM_BUF (16) | Per-buffer occupancy from the buffers |
| steer_accept | output | 1 | Instruction taken this cycle |
| steer_stall | output | 1 | Instruction refused this cycle |
| steer_buf | output | BUF_W (4) | Chosen buffer ID |
| ntf_valid | output | 2 | Per-source notification to the producer buffer |
| ntf_buf0 | output | BUF_W (4) | Producer buffer of source 0 |
| ntf_buf1 | output | BUF_W (4) | Producer buffer of source 1 |
| ntf_eu | output | EU_W (3) | EU of the chosen buffer, to record in the producer entry |

## Verification
Every cycle, the assertions check the following. A new chain or a spilled consumer always lands in a buffer whose empty flag is set. A stall never comes with an accept, and no notification is raised without an accept. A destination write leaves a live entry with no consumer. A matching completion kills its entry, and a filled buffer reads as not empty on the next cycle. Only the bench scenarios can show that the right buffer is chosen in the priority order. The same holds for the first-cluster-only rule of a single spilling consumer and the fallback to the second producer's cluster. The bench scenarios also show that a mismatched completion tag changes nothing, that the one-cycle lag lets a drained buffer be reused, and that a stall leaves the state untouched.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_NEW    = 2'd1,
    PICK_APPEND = 2'd2,
    PICK_SPILL  = 2'd3
  } pick_kind_e;
endpackage

// File: rtl/steer_prod_table.sv
`timescale 1ns/1ps
module steer_prod_table #(
  parameter int NUM_REGS = 16,
  parameter int BUF_W    = 4,
  parameter int TAG_W    = 4,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] rd0_idx,
  input  logic [REG_W-1:0] rd1_idx,
  output logic             rd0_live,
  output logic [BUF_W-1:0] rd0_buf,
  output logic             rd0_cons,
  output logic             rd1_live,
  output logic [BUF_W-1:0] rd1_buf,
  output logic             rd1_cons,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_reg,
  input  logic [BUF_W-1:0] wr_buf,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             mark0_en,
  input  logic [REG_W-1:0] mark0_reg,
  input  logic             mark1_en,
  input  logic [REG_W-1:0] mark1_reg,
  input  logic             cmp_valid,
  input  logic [BUF_W-1:0] cmp_buf,
  input  logic [TAG_W-1:0] cmp_tag
);
  logic [NUM_REGS-1:0] live_q, live_d;
  logic [NUM_REGS-1:0] cons_q, cons_d;
  logic [BUF_W-1:0]    buf_q [NUM_REGS];
  logic [TAG_W-1:0]    tag_q [NUM_REGS];

  assign rd0_live = live_q[rd0_idx];
  assign rd0_buf  = buf_q[rd0_idx];
  assign rd0_cons = cons_q[rd0_idx];
  assign rd1_live = live_q[rd1_idx];
  assign rd1_buf  = buf_q[rd1_idx];
  assign rd1_cons = cons_q[rd1_idx];

  always_comb begin
    live_d = live_q;
    cons_d = cons_q;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (cmp_valid && live_q[r] && buf_q[r] == cmp_buf && tag_q[r] == cmp_tag) begin
        live_d[r] = 1'b0;
        cons_d[r] = 1'b0;
      end
      if ((mark0_en && mark0_reg == REG_W'(r)) || (mark1_en && mark1_reg == REG_W'(r)))
        cons_d[r] = 1'b1;
      if (wr_en && wr_reg == REG_W'(r)) begin
        live_d[r] = 1'b1;
        cons_d[r] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      cons_q <= '0;
    end else begin
      live_q <= live_d;
      cons_q <= cons_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      buf_q[wr_reg] <= wr_buf;
      tag_q[wr_reg] <= wr_tag;
    end
  end

  p_dest_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> live_q[$past(wr_reg)] && !cons_q[$past(wr_reg)]);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_cmp_chk
    p_complete_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && live_q[r] && buf_q[r] == cmp_buf && tag_q[r] == cmp_tag &&
       !(wr_en && wr_reg == REG_W'(r))) |=> !live_q[r]);
  end
endmodule

// File: rtl/steer_empty_track.sv
`timescale 1ns/1ps
module steer_empty_track #(
  parameter int NUM_BUF      = 16,
  parameter int BUF_W        = 4,
  parameter int BUFS_PER_CLU = 8,
  parameter int NUM_CLU      = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fill_en,
  input  logic [BUF_W-1:0]                fill_buf,
  input  logic [NUM_BUF-1:0]              occupied,
  output logic [NUM_BUF-1:0]              empty_vec,
  output logic [NUM_CLU-1:0]              clu_found,
  output logic [NUM_CLU-1:0][BUF_W-1:0]   clu_idx,
  output logic                            any_found,
  output logic [BUF_W-1:0]                any_idx
);
  logic [NUM_BUF-1:0] empty_q, empty_d;

  assign empty_vec = empty_q;

  always_comb begin
    for (int b = 0; b < NUM_BUF; b++) begin
      if (fill_en && fill_buf == BUF_W'(b)) empty_d[b] = 1'b0;
      else if (!occupied[b])                empty_d[b] = 1'b1;
      else                                  empty_d[b] = empty_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_q <= '1;
    else        empty_q <= empty_d;
  end

  always_comb begin
    any_found = 1'b0;
    any_idx   = '0;
    for (int b = NUM_BUF-1; b >= 0; b--) begin
      if (empty_q[b]) begin
        any_found = 1'b1;
        any_idx   = BUF_W'(b);
      end
    end
  end

  for (genvar c = 0; c < NUM_CLU; c++) begin : g_clu
    logic             fnd;
    logic [BUF_W-1:0] idx;
    always_comb begin
      fnd = 1'b0;
      idx = '0;
      for (int i = BUFS_PER_CLU-1; i >= 0; i--) begin
        if ((c*BUFS_PER_CLU + i) < NUM_BUF) begin
          if (empty_q[c*BUFS_PER_CLU + i]) begin
            fnd = 1'b1;
            idx = BUF_W'(c*BUFS_PER_CLU + i);
          end
        end
      end
    end
    assign clu_found[c] = fnd;
    assign clu_idx[c]   = idx;
  end

  p_fill_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !empty_vec[$past(fill_buf)]);
endmodule

// File: rtl/dep_steer.sv
`timescale 1ns/1ps
module dep_steer #(
  parameter int NUM_EU      = 8,
  parameter int BUFS_PER_EU = 2,
  parameter int EU_PER_CLU  = 4,
  parameter int NUM_REGS    = 16,
  parameter int TAG_W       = 4,
  localparam int NUM_BUF      = NUM_EU * BUFS_PER_EU,
  localparam int BUF_W        = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int EU_W         = (NUM_EU > 1) ? $clog2(NUM_EU) : 1,
  localparam int REG_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NUM_CLU      = (NUM_EU + EU_PER_CLU - 1) / EU_PER_CLU,
  localparam int BUFS_PER_CLU = EU_PER_CLU * BUFS_PER_EU,
  localparam int CLU_W        = (NUM_CLU > 1) ? $clog2(NUM_CLU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_dst_vld,
  input  logic [REG_W-1:0]   in_dst,
  input  logic               in_src0_vld,
  input  logic [REG_W-1:0]   in_src0,
  input  logic               in_src1_vld,
  input  logic [REG_W-1:0]   in_src1,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic               cmp_valid,
  input  logic [BUF_W-1:0]   cmp_buf,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic [NUM_BUF-1:0] buf_occupied,
  output logic               steer_accept,
  output logic               steer_stall,
  output logic [BUF_W-1:0]   steer_buf,
  output logic [1:0]         ntf_valid,
  output logic [BUF_W-1:0]   ntf_buf0,
  output logic [BUF_W-1:0]   ntf_buf1,
  output logic [EU_W-1:0]    ntf_eu
);
  import steer_pkg::*;

  function automatic logic [EU_W-1:0] eu_of(input logic [BUF_W-1:0] b);
    return EU_W'(32'(b) / BUFS_PER_EU);
  endfunction

  function automatic logic [CLU_W-1:0] clu_of(input logic [BUF_W-1:0] b);
    return CLU_W'(32'(b) / BUFS_PER_CLU);
  endfunction

  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic             rd0_live, rd0_cons, rd1_live, rd1_cons;
  logic [BUF_W-1:0] rd0_buf, rd1_buf;
  logic             out0, out1, free0, free1;
  logic             pick_ok;
  logic [BUF_W-1:0] pick_buf;
  pick_kind_e       pick_kind;
  logic [NUM_BUF-1:0]            empty_vec;
  logic [NUM_CLU-1:0]            clu_found;
  logic [NUM_CLU-1:0][BUF_W-1:0] clu_idx;
  logic             any_found;
  logic [BUF_W-1:0] any_idx;
  logic [CLU_W-1:0] clu0, clu1;
  logic [EU_W-1:0]  pick_eu;

  steer_prod_table #(.NUM_REGS(NUM_REGS), .BUF_W(BUF_W), .TAG_W(TAG_W)) i_table (
    .clk(clk), .rst_n(rst_int_n),
    .rd0_idx(in_src0), .rd1_idx(in_src1),
    .rd0_live(rd0_live), .rd0_buf(rd0_buf), .rd0_cons(rd0_cons),
    .rd1_live(rd1_live), .rd1_buf(rd1_buf), .rd1_cons(rd1_cons),
    .wr_en(steer_accept && in_dst_vld), .wr_reg(in_dst), .wr_buf(pick_buf), .wr_tag(in_tag),
    .mark0_en(steer_accept && out0), .mark0_reg(in_src0),
    .mark1_en(steer_accept && out1), .mark1_reg(in_src1),
    .cmp_valid(cmp_valid), .cmp_buf(cmp_buf), .cmp_tag(cmp_tag)
  );

  steer_empty_track #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W), .BUFS_PER_CLU(BUFS_PER_CLU),
                      .NUM_CLU(NUM_CLU)) i_empty (
    .clk(clk), .rst_n(rst_int_n),
    .fill_en(steer_accept), .fill_buf(pick_buf), .occupied(buf_occupied),
    .empty_vec(empty_vec), .clu_found(clu_found), .clu_idx(clu_idx),
    .any_found(any_found), .any_idx(any_idx)
  );

  assign out0  = in_src0_vld && rd0_live;
  assign out1  = in_src1_vld && rd1_live && !(out0 && in_src1 == in_src0);
  assign free0 = out0 && !rd0_cons;
  assign free1 = out1 && !rd1_cons;
  assign clu0  = clu_of(rd0_buf);
  assign clu1  = clu_of(rd1_buf);

  always_comb begin
    pick_ok   = 1'b0;
    pick_buf  = '0;
    pick_kind = PICK_NONE;
    if (!out0 && !out1) begin
      pick_ok = any_found; pick_buf = any_idx; pick_kind = PICK_NEW;
    end else if (free0) begin
      pick_ok = 1'b1; pick_buf = rd0_buf; pick_kind = PICK_APPEND;
    end else if (free1) begin
      pick_ok = 1'b1; pick_buf = rd1_buf; pick_kind = PICK_APPEND;
    end else if (out0 && clu_found[clu0]) begin
      pick_ok = 1'b1; pick_buf = clu_idx[clu0]; pick_kind = PICK_SPILL;
    end else if (out1 && clu_found[clu1]) begin
      pick_ok = 1'b1; pick_buf = clu_idx[clu1]; pick_kind = PICK_SPILL;
    end
  end

  assign steer_accept = in_valid && pick_ok;
  assign steer_stall  = in_valid && !pick_ok;
  assign steer_buf    = pick_buf;
  assign pick_eu      = eu_of(pick_buf);
  assign ntf_eu       = pick_eu;
  assign ntf_buf0     = rd0_buf;
  assign ntf_buf1     = rd1_buf;
  assign ntf_valid[0] = steer_accept && out0 && (eu_of(rd0_buf) != pick_eu);
  assign ntf_valid[1] = steer_accept && out1 && (eu_of(rd1_buf) != pick_eu);

  p_new_chain_empty_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (steer_accept && pick_kind == PICK_NEW) |-> empty_vec[steer_buf]);
  p_spill_empty_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (steer_accept && pick_kind == PICK_SPILL) |-> empty_vec[steer_buf]);
  p_stall_excl_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    steer_stall |-> !steer_accept);
  p_notify_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ntf_valid != 2'b00) |-> steer_accept);
endmodule

// File: tb/test_dep_steer.sv
`timescale 1ns/1ps
module test_dep_steer;
  localparam int NB = 16;
  localparam int NR = 16;

  typedef struct {
    logic       acc;
    logic       stl;
    logic [3:0] bid;
    logic [1:0] nv;
    logic [3:0] nb0;
    logic [3:0] nb1;
    logic [2:0] neu;
    string      why;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_dst_vld = 0, in_src0_vld = 0, in_src1_vld = 0;
  logic [3:0] in_dst = 0, in_src0 = 0, in_src1 = 0, in_tag = 0;
  logic cmp_valid = 0;
  logic [3:0] cmp_buf = 0, cmp_tag = 0;
  logic [NB-1:0] buf_occupied = '0;
  logic steer_accept, steer_stall;
  logic [3:0] steer_buf, ntf_buf0, ntf_buf1;
  logic [1:0] ntf_valid;
  logic [2:0] ntf_eu;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  logic       m_live [NR];
  logic       m_cons [NR];
  logic [3:0] m_buf  [NR];
  logic [3:0] m_tag  [NR];
  logic       m_emp  [NB];
  logic       m_occ  [NB];
  logic       p_cmp = 0;
  logic [3:0] p_cbuf = 0, p_ctag = 0;

  always #2.5 clk = ~clk;

  dep_steer i_dep_steer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_vld(in_dst_vld), .in_dst(in_dst),
    .in_src0_vld(in_src0_vld), .in_src0(in_src0), .in_src1_vld(in_src1_vld), .in_src1(in_src1),
    .in_tag(in_tag), .cmp_valid(cmp_valid), .cmp_buf(cmp_buf), .cmp_tag(cmp_tag),
    .buf_occupied(buf_occupied), .steer_accept(steer_accept), .steer_stall(steer_stall),
    .steer_buf(steer_buf), .ntf_valid(ntf_valid), .ntf_buf0(ntf_buf0), .ntf_buf1(ntf_buf1),
    .ntf_eu(ntf_eu)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int low_empty(input int lo, input int hi);
    for (int b = lo; b <= hi; b++) if (m_emp[b]) return b;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R6 accept", steer_accept, e.acc);
      chk("R6 stall", steer_stall, e.stl);
      if (e.acc) chk(e.why, steer_buf, e.bid);
      chk("R7 ntf_valid", ntf_valid, e.nv);
      if (e.nv[0]) begin chk("R7 ntf_buf0", ntf_buf0, e.nb0); chk("R7 ntf_eu", ntf_eu, e.neu); end
      if (e.nv[1]) begin chk("R7 ntf_buf1", ntf_buf1, e.nb1); chk("R7 ntf_eu", ntf_eu, e.neu); end
    end
  end

  task automatic complete_next(input logic [3:0] b, input logic [3:0] t);
    p_cmp = 1; p_cbuf = b; p_ctag = t;
  endtask

  task automatic step(input logic v, input logic dv, input int d, input logic s0v, input int s0,
                      input logic s1v, input int s1, input int tg, input string why);
    exp_t e;
    logic o0, o1, f0, f1, ok;
    int pb, kind;
    @(posedge clk); #1;
    in_valid = v; in_dst_vld = dv; in_dst = 4'(d); in_src0_vld = s0v; in_src0 = 4'(s0);
    in_src1_vld = s1v; in_src1 = 4'(s1); in_tag = 4'(tg);
    cmp_valid = p_cmp; cmp_buf = p_cbuf; cmp_tag = p_ctag;
    for (int b = 0; b < NB; b++) buf_occupied[b] = m_occ[b];
    o0 = s0v && m_live[s0];
    o1 = s1v && m_live[s1] && !(o0 && s1 == s0);
    f0 = o0 && !m_cons[s0];
    f1 = o1 && !m_cons[s1];
    pb = -1; kind = 0;
    if (!o0 && !o1) begin pb = low_empty(0, NB-1); kind = 2; end
    else if (f0) begin pb = m_buf[s0]; kind = 3; end
    else if (f1) begin pb = m_buf[s1]; kind = 3; end
    else begin
      kind = (o0 && o1) ? 5 : 4;
      if (o0) pb = low_empty(m_buf[s0]/8*8, m_buf[s0]/8*8+7);
      if (pb < 0 && o1) pb = low_empty(m_buf[s1]/8*8, m_buf[s1]/8*8+7);
    end
    if (kind == 3 && o0 && o1) kind = 5;
    ok = v && pb >= 0;
    e.acc = ok; e.stl = v && !ok; e.bid = 4'(pb < 0 ? 0 : pb);
    e.nv[0] = ok && o0 && (m_buf[s0]/2 != pb/2);
    e.nv[1] = ok && o1 && (m_buf[s1]/2 != pb/2);
    e.nb0 = m_buf[s0]; e.nb1 = m_buf[s1]; e.neu = 3'(pb/2);
    e.why = (why != "") ? why : $sformatf("R%0d steer", kind);
    exp_q.push_back(e);
    if (p_cmp)
      for (int r = 0; r < NR; r++)
        if (m_live[r] && m_buf[r] == p_cbuf && m_tag[r] == p_ctag) begin
          m_live[r] = 0; m_cons[r] = 0;
        end
    if (ok) begin
      if (o0) m_cons[s0] = 1;
      if (o1) m_cons[s1] = 1;
      if (dv) begin m_live[d] = 1; m_cons[d] = 0; m_buf[d] = 4'(pb); m_tag[d] = 4'(tg); end
    end
    for (int b = 0; b < NB; b++) if (!m_occ[b]) m_emp[b] = 1;
    if (ok) begin m_emp[pb] = 0; m_occ[pb] = 1; end
    p_cmp = 0;
  endtask

  task automatic nop();
    step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int r = 0; r < NR; r++) begin m_live[r] = 0; m_cons[r] = 0; m_buf[r] = 0; m_tag[r] = 0; end
    for (int b = 0; b < NB; b++) begin m_emp[b] = 1; m_occ[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset accept", steer_accept, 0);
    chk("R1 reset stall", steer_stall, 0);
    chk("R1 reset ntf", ntf_valid, 0);

    step(1, 1, 1, 0, 0, 0, 0, 1, "R1 first chain buf0");
    step(1, 1, 2, 1, 1, 0, 0, 2, "R3 append");
    step(1, 1, 3, 1, 1, 0, 0, 3, "R4 spill same cluster");
    step(1, 1, 4, 1, 1, 0, 0, 4, "R4 spill cross EU");
    step(1, 1, 5, 1, 3, 1, 4, 5, "R5 source0 free");
    step(1, 1, 6, 1, 1, 1, 2, 6, "R5 source1 free");
    step(1, 1, 11, 1, 1, 1, 3, 7, "R5 neither free");
    complete_next(4'd2, 4'd9);
    step(1, 1, 7, 1, 4, 0, 0, 8, "R9 mismatched tag ignored");
    complete_next(4'd2, 4'd4);
    nop();
    step(1, 1, 8, 1, 4, 0, 0, 9, "R9 completed source not outstanding");
    step(1, 1, 1, 0, 0, 0, 0, 10, "R8 dest overwrite");
    step(1, 1, 12, 1, 1, 0, 0, 11, "R8 consumer bit cleared");
    m_occ[0] = 0;
    nop();
    step(1, 1, 13, 0, 0, 0, 0, 12, "R10 drained buffer reused");
    step(1, 1, 14, 0, 0, 0, 0, 13, "R2 last in cluster0");
    step(1, 1, 15, 1, 1, 0, 0, 14, "R4 stall cluster full");
    step(1, 1, 9, 0, 0, 0, 0, 15, "R6 stall left state");
    step(1, 1, 10, 1, 9, 0, 0, 1, "R3 append cluster1");
    step(1, 1, 0, 1, 1, 1, 9, 2, "R5 fallback second cluster");

    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int r;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) m_occ[lf[7:4]] = 0;
      if (lf[4:3] == 2'd1) begin
        r = int'(lf[11:8]);
        if (m_live[r]) complete_next(m_buf[r], lf[0] ? m_tag[r] : m_tag[r] + 4'd1);
      end
      step(lf[15:12] != 0, lf[5], int'(lf[9:6]), lf[1], int'(lf[15:12]),
           lf[3], int'(lf[13:10]), n & 15, "");
    end
    nop();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule